// File: doc/BRIEF.md
# I2C Controller Event Flags and Enable Handshake

This block collects the event flags of an I2C controller and turns them into one interrupt line. The bus engine reports its events as single-cycle pulses. The block also watches the levels of the transmit and receive queues and detects any push or pop those queues cannot accept. Software reaches the flags through a small word-addressed register port. The port exposes a raw view, a mask, a masked view, and a set of clear registers. Reading a clear register clears its flag. Writing to a clear register does nothing.

The block also carries the run/stop handshake. Software requests a start or a stop through the enable register. The reported state follows only once the change has finished. A stop finishes only while the bus engine is idle. At that moment the block emits a one-cycle flush pulse that empties both queues.

The three queue qualifiers (`tx_wr_ok`, `rx_in_ok`, `rx_rd_ok`) act as same-cycle ready signals for the queue beside the block. A push or pop offered while its qualifier is low is refused. The refusal is recorded as a flag and is never held waiting. There is no back-pressure in any other direction.

Top module: `evt_status_unit`

## Requirements
- R1: After reset the mask, both thresholds, the enable request and the enable status read 0, and `irq` is 0. With both queue levels at 0, the raw view (address 0) reads 0x0010.
- R2: A pulse on `engine_evt[k]` sets raw bit 5+k at the next edge: 5 read request, 6 transmit abort, 7 receive done, 8 activity, 9 stop, 10 start/restart, 11 general call. The bit stays set until it is cleared.
- R3: The masked view (address 2) equals raw AND mask (mask at address 1, bits 11:0). `irq` is high exactly when the masked view is non-zero.
- R4: Reading a per-source clear register returns that flag in bit 0 and clears only that flag at the same edge. The addresses are 8 receive underflow (bit 0), 9 receive overflow (bit 1), 10 transmit overflow (bit 3), and 11 to 17 for raw bits 5 to 11 in order.
- R5: Reading the combined clear register (address 3) returns the raw view and clears every latched flag at once.
- R6: When a flag's set condition and its clear read fall in the same cycle, the flag ends up set.
- R7: Raw bit 4 is high while `tx_level` <= the transmit threshold (address 5). Raw bit 2 is high while `rx_level` > the receive threshold (address 4). Neither bit is latched, and clear reads do not change them.
- R8: `tx_wr` while `tx_level` equals DEPTH drives `tx_wr_ok` low and sets raw bit 3. Below DEPTH, `tx_wr_ok` follows `tx_wr`.
- R9: `rx_in` while `rx_level` equals DEPTH drives `rx_in_ok` low and sets raw bit 1.
- R10: `rx_rd` while `rx_level` is 0 drives `rx_rd_ok` low and sets raw bit 0. With a non-zero level the read is accepted and sets nothing.
- R11: Writing 1 to address 6 bit 0 raises `run` at once. `en_active` (also address 7 bit 0) rises one cycle after `run`.
- R12: After 0 is written to address 6, `en_active` stays high until a cycle in which `engine_idle` is high. In that cycle `flush` is high for exactly one cycle, and `en_active` is low from the next cycle on.
- R13: Writes to addresses 0, 2, 3, 7 and 8 to 17 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (clear registers act on it) |
| reg_addr | input | 5 | Word address |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data, valid in the cycle of `reg_rd`, 0 otherwise |
| engine_evt | input | 7 | Event pulses from the bus engine (raw bits 5 to 11) |
| engine_idle | input | 1 | Bus engine has no transfer in progress |
| tx_level | input | LVL_W | Transmit queue fill level |
| rx_level | input | LVL_W | Receive queue fill level |
| tx_wr | input | 1 | Software push offered to the transmit queue |
| rx_in | input | 1 | Engine byte offered to the receive queue |
| rx_rd | input | 1 | Software pop offered to the receive queue |
| tx_wr_ok | output | 1 | Transmit push accepted |
| rx_in_ok | output | 1 | Receive push accepted |
| rx_rd_ok | output | 1 | Receive pop accepted (otherwise the queue returns 0) |
| irq | output | 1 | Interrupt line |
| run | output | 1 | Enable request to the bus engine |
| en_active | output | 1 | Enable status |
| flush | output | 1 | One-cycle queue flush at stop completion |

## Verification
The bench uses DEPTH = 4, which gives LVL_W = 3. A full queue is then a level of 4, so both overflow edges and the empty underflow edge each take a single level setting. With a threshold of 2, the at-or-below and above comparisons can be driven to either side with small values. This depth also keeps every level and threshold field narrow enough that a wrong bit position appears directly in the raw value read back.

// File: rtl/evt_pkg.sv
package evt_pkg;
  localparam int NFLAG  = 12;
  localparam int ADDR_W = 5;
  localparam int REG_W  = 16;

  // flag positions (decoded by software)
  localparam int B_RXUF  = 0;
  localparam int B_RXOF  = 1;
  localparam int B_RXTH  = 2;
  localparam int B_TXOF  = 3;
  localparam int B_TXTH  = 4;
  localparam int B_RDREQ = 5;
  localparam int NENG    = 7;

  // latched flags; bits 2 and 4 follow queue levels
  localparam logic [NFLAG-1:0] LATCH_MASK = 12'hFEB;

  localparam logic [ADDR_W-1:0] A_RAW      = 5'd0;
  localparam logic [ADDR_W-1:0] A_MASK     = 5'd1;
  localparam logic [ADDR_W-1:0] A_MASKED   = 5'd2;
  localparam logic [ADDR_W-1:0] A_CLR_ALL  = 5'd3;
  localparam logic [ADDR_W-1:0] A_RXTHR    = 5'd4;
  localparam logic [ADDR_W-1:0] A_TXTHR    = 5'd5;
  localparam logic [ADDR_W-1:0] A_EN       = 5'd6;
  localparam logic [ADDR_W-1:0] A_ENST     = 5'd7;
  localparam logic [ADDR_W-1:0] A_CLR_RXUF = 5'd8;
  localparam logic [ADDR_W-1:0] A_CLR_RXOF = 5'd9;
  localparam logic [ADDR_W-1:0] A_CLR_TXOF = 5'd10;
  localparam logic [ADDR_W-1:0] A_CLR_ENG0 = 5'd11;

  function automatic logic [NFLAG-1:0] clr_sel(input logic [ADDR_W-1:0] a);
    logic [NFLAG-1:0] v;
    v = '0;
    if (a == A_CLR_RXUF) v[B_RXUF] = 1'b1;
    if (a == A_CLR_RXOF) v[B_RXOF] = 1'b1;
    if (a == A_CLR_TXOF) v[B_TXOF] = 1'b1;
    for (int k = 0; k < NENG; k++)
      if (a == ADDR_W'(int'(A_CLR_ENG0) + k)) v[B_RDREQ + k] = 1'b1;
    return v;
  endfunction
endpackage

// File: rtl/evt_flag_bank.sv
module evt_flag_bank
  import evt_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NFLAG-1:0] set_vec,
  input  logic [NFLAG-1:0] clr_vec,
  output logic [NFLAG-1:0] flags
);
  for (genvar i = 0; i < NFLAG; i++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          flags[i] <= 1'b0;
      else if (set_vec[i]) flags[i] <= 1'b1;   // set beats clear
      else if (clr_vec[i]) flags[i] <= 1'b0;
    end
  end
endmodule

// File: rtl/evt_level_cmp.sv
module evt_level_cmp #(
  parameter int DEPTH = 16,
  parameter int LVL_W = 5
) (
  input  logic [LVL_W-1:0] tx_level,
  input  logic [LVL_W-1:0] rx_level,
  input  logic [LVL_W-1:0] tx_thr,
  input  logic [LVL_W-1:0] rx_thr,
  input  logic             tx_wr,
  input  logic             rx_in,
  input  logic             rx_rd,
  output logic             tx_below,
  output logic             rx_above,
  output logic             tx_ovf,
  output logic             rx_ovf,
  output logic             rx_udf,
  output logic             tx_wr_ok,
  output logic             rx_in_ok,
  output logic             rx_rd_ok
);
  localparam logic [LVL_W-1:0] FULL = LVL_W'(DEPTH);

  logic tx_full, rx_full, rx_empty;

  always_comb begin
    tx_full  = (tx_level == FULL);
    rx_full  = (rx_level == FULL);
    rx_empty = (rx_level == '0);
    tx_below = (tx_level <= tx_thr);
    rx_above = (rx_level > rx_thr);
    tx_ovf   = tx_wr & tx_full;
    rx_ovf   = rx_in & rx_full;
    rx_udf   = rx_rd & rx_empty;
    tx_wr_ok = tx_wr & ~tx_full;
    rx_in_ok = rx_in & ~rx_full;
    rx_rd_ok = rx_rd & ~rx_empty;
  end
endmodule

// File: rtl/evt_enable_ctl.sv
module evt_enable_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic engine_idle,
  output logic en_active,
  output logic flush
);
  assign flush = ~run & en_active & engine_idle;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 en_active <= 1'b0;
    else if (run && !en_active) en_active <= 1'b1;
    else if (flush)             en_active <= 1'b0;
  end
endmodule

// File: rtl/evt_reg_port.sv
module evt_reg_port
  import evt_pkg::*;
#(
  parameter int LVL_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  input  logic [NFLAG-1:0]  raw,
  input  logic              en_active,
  output logic [NFLAG-1:0]  mask,
  output logic [LVL_W-1:0]  tx_thr,
  output logic [LVL_W-1:0]  rx_thr,
  output logic              run,
  output logic [NFLAG-1:0]  clr_vec
);
  logic [NFLAG-1:0] sel;
  logic             unused_wdata;

  assign unused_wdata = ^reg_wdata[REG_W-1:NFLAG];
  assign sel          = clr_sel(reg_addr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask   <= '0;
      tx_thr <= '0;
      rx_thr <= '0;
      run    <= 1'b0;
    end else if (reg_wr) begin
      case (reg_addr)
        A_MASK:  mask   <= reg_wdata[NFLAG-1:0];
        A_TXTHR: tx_thr <= reg_wdata[LVL_W-1:0];
        A_RXTHR: rx_thr <= reg_wdata[LVL_W-1:0];
        A_EN:    run    <= reg_wdata[0];
        default: ;
      endcase
    end
  end

  always_comb begin
    clr_vec = '0;
    if (reg_rd) clr_vec = (reg_addr == A_CLR_ALL) ? LATCH_MASK : sel;
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_rd) begin
      case (reg_addr)
        A_RAW:     reg_rdata[NFLAG-1:0] = raw;
        A_MASK:    reg_rdata[NFLAG-1:0] = mask;
        A_MASKED:  reg_rdata[NFLAG-1:0] = raw & mask;
        A_CLR_ALL: reg_rdata[NFLAG-1:0] = raw;
        A_TXTHR:   reg_rdata[LVL_W-1:0] = tx_thr;
        A_RXTHR:   reg_rdata[LVL_W-1:0] = rx_thr;
        A_EN:      reg_rdata[0]         = run;
        A_ENST:    reg_rdata[0]         = en_active;
        default:   reg_rdata[0]         = |(raw & sel);
      endcase
    end
  end
endmodule

// File: rtl/evt_status_unit.sv
module evt_status_unit
  import evt_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  input  logic [NENG-1:0]   engine_evt,
  input  logic              engine_idle,
  input  logic [LVL_W-1:0]  tx_level,
  input  logic [LVL_W-1:0]  rx_level,
  input  logic              tx_wr,
  input  logic              rx_in,
  input  logic              rx_rd,
  output logic              tx_wr_ok,
  output logic              rx_in_ok,
  output logic              rx_rd_ok,
  output logic              irq,
  output logic              run,
  output logic              en_active,
  output logic              flush
);
  logic [NFLAG-1:0] latched, raw_status, mask_q, set_vec, clr_vec, live;
  logic [LVL_W-1:0] tx_thr, rx_thr;
  logic             tx_below, rx_above, tx_ovf, rx_ovf, rx_udf;

  evt_level_cmp #(.DEPTH(DEPTH), .LVL_W(LVL_W)) u_lvl (
    .tx_level(tx_level), .rx_level(rx_level), .tx_thr(tx_thr), .rx_thr(rx_thr),
    .tx_wr(tx_wr), .rx_in(rx_in), .rx_rd(rx_rd),
    .tx_below(tx_below), .rx_above(rx_above),
    .tx_ovf(tx_ovf), .rx_ovf(rx_ovf), .rx_udf(rx_udf),
    .tx_wr_ok(tx_wr_ok), .rx_in_ok(rx_in_ok), .rx_rd_ok(rx_rd_ok)
  );

  assign set_vec = {engine_evt, 1'b0, tx_ovf, 1'b0, rx_ovf, rx_udf};
  assign live    = {{NENG{1'b0}}, tx_below, 1'b0, rx_above, 2'b00};

  evt_flag_bank u_flags (
    .clk(clk), .rst_n(rst_n), .set_vec(set_vec), .clr_vec(clr_vec), .flags(latched)
  );

  assign raw_status = (latched & LATCH_MASK) | live;
  assign irq        = |(raw_status & mask_q);

  evt_reg_port #(.LVL_W(LVL_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .raw(raw_status), .en_active(en_active), .mask(mask_q),
    .tx_thr(tx_thr), .rx_thr(rx_thr), .run(run), .clr_vec(clr_vec)
  );

  evt_enable_ctl u_en (
    .clk(clk), .rst_n(rst_n), .run(run), .engine_idle(engine_idle),
    .en_active(en_active), .flush(flush)
  );
endmodule

// File: rtl/evt_status_chk.sv
module evt_status_chk
  import evt_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int LVL_W = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_rd,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [NENG-1:0]   engine_evt,
  input logic              engine_idle,
  input logic [LVL_W-1:0]  tx_level,
  input logic [LVL_W-1:0]  rx_level,
  input logic              tx_wr,
  input logic              rx_in,
  input logic              rx_rd,
  input logic              rx_in_ok,
  input logic [NFLAG-1:0]  raw,
  input logic [NFLAG-1:0]  mask,
  input logic              irq,
  input logic              run,
  input logic              en_active,
  input logic              flush
);
  // R2
  gcall_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    engine_evt[NENG-1] |=> raw[NFLAG-1]);

  // R3
  irq_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq == ((raw & mask) != '0));

  // R4
  gcall_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && reg_addr == 5'd17 && !engine_evt[NENG-1]) |=> !raw[NFLAG-1]);

  // R5
  clear_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && reg_addr == A_CLR_ALL && engine_evt == '0 && !tx_wr && !rx_in && !rx_rd)
    |=> ((raw & LATCH_MASK) == '0));

  // R8
  tx_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_wr && tx_level == LVL_W'(DEPTH)) |=> raw[B_TXOF]);

  // R9
  rx_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_in && rx_level == LVL_W'(DEPTH)) |-> !rx_in_ok);

  // R11
  enable_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(en_active) |-> $past(run));

  // R12
  disable_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(en_active) |-> ($past(engine_idle) && !$past(run)));

  // R12
  flush_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !flush);
endmodule

bind evt_status_unit evt_status_chk #(.DEPTH(DEPTH), .LVL_W(LVL_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_rd(reg_rd), .reg_addr(reg_addr),
  .engine_evt(engine_evt), .engine_idle(engine_idle),
  .tx_level(tx_level), .rx_level(rx_level), .tx_wr(tx_wr), .rx_in(rx_in),
  .rx_rd(rx_rd), .rx_in_ok(rx_in_ok), .raw(raw_status), .mask(mask_q),
  .irq(irq), .run(run), .en_active(en_active), .flush(flush)
);

// File: tb/evt_status_unit_bench.sv
module evt_status_unit_bench;
  localparam int DEPTH = 4;
  localparam int LVL_W = $clog2(DEPTH + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_wr = 1'b0, reg_rd = 1'b0;
  logic [4:0]  reg_addr = '0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic [6:0]  engine_evt = '0;
  logic engine_idle = 1'b1;
  logic [LVL_W-1:0] tx_level = '0, rx_level = '0;
  logic tx_wr = 1'b0, rx_in = 1'b0, rx_rd = 1'b0;
  logic tx_wr_ok, rx_in_ok, rx_rd_ok, irq, run, en_active, flush;

  int checks = 0;
  int errors = 0;
  logic [15:0] exp_q[$];
  string       tag_q[$];

  always #10 clk = ~clk;

  evt_status_unit #(.DEPTH(DEPTH)) u_evt_status_unit (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .engine_evt(engine_evt), .engine_idle(engine_idle),
    .tx_level(tx_level), .rx_level(rx_level), .tx_wr(tx_wr), .rx_in(rx_in),
    .rx_rd(rx_rd), .tx_wr_ok(tx_wr_ok), .rx_in_ok(rx_in_ok), .rx_rd_ok(rx_rd_ok),
    .irq(irq), .run(run), .en_active(en_active), .flush(flush)
  );

  task automatic finish_up();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  task automatic chk(input logic [15:0] act, input logic [15:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // monitor: pops the scoreboard on every read strobe
  initial begin
    forever begin
      @(negedge clk);
      #4;
      if (reg_rd) begin
        if (exp_q.size() == 0) begin
          checks++; errors++;
          $display("FAIL scoreboard: actual %h expected none", reg_rdata);
        end else begin
          chk(reg_rdata, exp_q.pop_front(), tag_q.pop_front());
        end
      end
    end
  end

  // driver tasks start at a falling edge and return at the next one
  task automatic rd(input logic [4:0] a, input logic [15:0] exp, input string tag);
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    reg_rd = 1'b1; reg_addr = a;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic wr(input logic [4:0] a, input logic [15:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic pulse(input logic [6:0] v);
    engine_evt = v;
    @(negedge clk);
    engine_evt = '0;
  endtask

  initial begin
    #2000000;
    checks++; errors++;
    $display("FAIL watchdog: actual hung expected done");
    finish_up();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(5'd0, 16'h0010, "R1 raw");
    rd(5'd1, 16'h0000, "R1 mask");
    rd(5'd7, 16'h0000, "R1 enable status");
    #2 chk({15'd0, irq}, 16'd0, "R1 irq");
    @(negedge clk);

    // R7 live threshold flags
    tx_level = 3'd2;
    rd(5'd0, 16'h0000, "R7 tx above threshold");
    wr(5'd5, 16'd2);
    rd(5'd0, 16'h0010, "R7 tx at threshold");
    rx_level = 3'd1;
    rd(5'd0, 16'h0014, "R7 rx above threshold");
    rd(5'd3, 16'h0014, "R7 combined read");
    rd(5'd0, 16'h0014, "R7 not latched");
    tx_level = 3'd3; rx_level = 3'd0;
    rd(5'd0, 16'h0000, "R7 both released");

    // R2 latched engine events
    pulse(7'b0000001);
    rd(5'd0, 16'h0020, "R2 read request bit 5");
    pulse(7'b1000000);
    rd(5'd0, 16'h0820, "R2 general call bit 11");

    // R3 mask and irq
    wr(5'd1, 16'h0800);
    rd(5'd2, 16'h0800, "R3 masked");
    #2 chk({15'd0, irq}, 16'd1, "R3 irq high");
    @(negedge clk);
    wr(5'd1, 16'h0001);
    rd(5'd2, 16'h0000, "R3 masked none");
    #2 chk({15'd0, irq}, 16'd0, "R3 irq low");
    @(negedge clk);
    wr(5'd1, 16'h0000);

    // R4 per-source clears
    rd(5'd17, 16'h0001, "R4 general call clear");
    rd(5'd0, 16'h0020, "R4 only one cleared");
    rd(5'd17, 16'h0000, "R4 already clear");
    rd(5'd11, 16'h0001, "R4 read request clear");
    rd(5'd0, 16'h0000, "R4 all clear");

    // R8 transmit overflow
    tx_level = 3'd4; tx_wr = 1'b1;
    #2 chk({15'd0, tx_wr_ok}, 16'd0, "R8 refused");
    @(negedge clk);
    tx_wr = 1'b0;
    rd(5'd0, 16'h0008, "R8 overflow flag");
    tx_level = 3'd3; tx_wr = 1'b1;
    #2 chk({15'd0, tx_wr_ok}, 16'd1, "R8 accepted");
    @(negedge clk);
    tx_wr = 1'b0;
    rd(5'd10, 16'h0001, "R8 clear");

    // R9 receive overflow
    rx_level = 3'd4; rx_in = 1'b1;
    #2 chk({15'd0, rx_in_ok}, 16'd0, "R9 refused");
    @(negedge clk);
    rx_in = 1'b0;
    rd(5'd0, 16'h0006, "R9 overflow flag");
    rx_level = 3'd0;
    rd(5'd9, 16'h0001, "R9 clear");
    rd(5'd0, 16'h0000, "R9 all clear");

    // R10 receive underflow
    rx_rd = 1'b1;
    #2 chk({15'd0, rx_rd_ok}, 16'd0, "R10 refused");
    @(negedge clk);
    rx_rd = 1'b0;
    rd(5'd0, 16'h0001, "R10 underflow flag");
    rd(5'd8, 16'h0001, "R10 clear");
    rx_level = 3'd2; rx_rd = 1'b1;
    #2 chk({15'd0, rx_rd_ok}, 16'd1, "R10 accepted");
    @(negedge clk);
    rx_rd = 1'b0; rx_level = 3'd0;
    rd(5'd0, 16'h0000, "R10 no flag");

    // R5 combined clear
    pulse(7'b1111111);
    rd(5'd3, 16'h0FE0, "R5 combined returns raw");
    rd(5'd0, 16'h0000, "R5 all cleared");

    // R6 set beats clear
    pulse(7'b0000010);
    engine_evt = 7'b0000010;
    rd(5'd12, 16'h0001, "R6 clear during set");
    engine_evt = '0;
    rd(5'd0, 16'h0040, "R6 flag kept");
    rd(5'd3, 16'h0040, "R6 combined");

    // R13 read-only writes ignored
    pulse(7'b1000000);
    wr(5'd0, 16'hFFFF);
    wr(5'd7, 16'h0001);
    wr(5'd17, 16'h0001);
    wr(5'd3, 16'h0001);
    rd(5'd0, 16'h0800, "R13 raw unchanged");
    rd(5'd7, 16'h0000, "R13 status unchanged");
    rd(5'd3, 16'h0800, "R13 combined");

    // R11 enable handshake
    wr(5'd6, 16'h0001);
    #2 chk({14'd0, run, en_active}, 16'b10, "R11 request before status");
    @(negedge clk);
    #2 chk({15'd0, en_active}, 16'd1, "R11 status one cycle later");
    @(negedge clk);
    rd(5'd7, 16'h0001, "R11 status register");

    // R12 disable waits for idle
    engine_idle = 1'b0;
    wr(5'd6, 16'h0000);
    repeat (3) @(negedge clk);
    #2 chk({14'd0, en_active, flush}, 16'b10, "R12 held while busy");
    @(negedge clk);
    engine_idle = 1'b1;
    #2 chk({15'd0, flush}, 16'd1, "R12 flush");
    @(negedge clk);
    #2 chk({14'd0, en_active, flush}, 16'b00, "R12 stopped");
    @(negedge clk);
    rd(5'd7, 16'h0000, "R12 status register");

    @(negedge clk);
    #6;
    if (exp_q.size() != 0) begin
      checks++; errors++;
      $display("FAIL scoreboard: actual %0d left expected 0", exp_q.size());
    end
    finish_up();
  end
endmodule